// File: doc/BRIEF.md
# Paired-Row Write-Recovery Timing Combiner

This block serves a memory controller that pairs two DRAM rows across a rank of eight byte-wide chips. Each rank word is 64 bits and carries two single-precision floats, so each chip holds one byte of one float. For each chip position the block compares the write-recovery times of the two rows. The faster segment goes to a precise row and the slower segment goes to a companion row. The block returns the segment-selection map, the effective write-recovery time of the precise row, and the effective write-recovery time of the companion row.

The companion row can be run in an approximate mode. In that mode the chips that hold only the low-order mantissa bytes are left out of its worst-case timing. The sign, exponent and high mantissa of every float keep a guaranteed timing in every mode.

A request is presented together with a one-cycle `start` pulse. A small controller moves through three named states. `ST_IDLE` waits for `start` and captures the request; this is the idle→eval transition. `ST_EVAL` registers the combined results; this is the eval→report transition. `ST_REPORT` raises `done` for one cycle and returns to `ST_IDLE` on the report→idle transition.

Top module: `pair_row_twr_combiner`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `busy`, `done`, `swap_map`, `twr_fast` and `twr_slow` are all zero.
- R2: A `start` seen in the idle state is accepted. `busy` is high from the next cycle through the `done` cycle. `done` is high for exactly one cycle, two rising edges after the edge that accepted the request.
- R3: A `start` raised while `busy` is high is ignored. It produces no further `done`, and the reported result belongs to the accepted request.
- R4: Chip i occupies bits [5i+4:5i] of each row vector. `swap_map[i]` is 1 exactly when row B's value for chip i is strictly smaller than row A's. A tie gives 0, which keeps row A's segment in the fast row.
- R5: `twr_fast` equals the largest, over all eight chips, of the smaller of the two values at that chip.
- R6: In precise mode (`mode` = 0), `twr_slow` equals the largest, over all eight chips, of the larger of the two values at that chip.
- R7: In the two-chip approximate mode (`mode` = 1), chips 0 and 4 (mask 0x11) contribute zero to `twr_slow`.
- R8: In the four-chip approximate mode (`mode` = 2), chips 0, 1, 4 and 5 (mask 0x33) contribute zero to `twr_slow`.
- R9: The unused code `mode` = 3 gives the same results as precise mode.
- R10: `swap_map`, `twr_fast` and `twr_slow` change only on the edge that raises `done`, and hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled only when idle |
| mode | input | 2 | 0 precise, 1 approximate two chips, 2 approximate four chips, 3 treated as precise |
| twr_row_a | input | 40 | Row A write-recovery values, 5 bits per chip |
| twr_row_b | input | 40 | Row B write-recovery values, 5 bits per chip |
| busy | output | 1 | A request is in flight |
| done | output | 1 | One-cycle result strobe |
| swap_map | output | 8 | Per-chip flag, 1 when the fast row takes row B's segment |
| twr_fast | output | 5 | Effective write-recovery time of the precise row |
| twr_slow | output | 5 | Effective write-recovery time of the companion row |

## Verification
The hardest case to reach from the ports is a second request arriving while the first is still in flight. It must arrive in the evaluation cycle and again in the report cycle, and it must carry different data and a different mode. The stimulus holds `start` high across both busy cycles with such a request. The scoreboard then expects exactly one result, which must match the first request. An unexpected extra `done` is flagged.

The approximate modes are driven with the largest value placed only on the masked chips. This makes any leak of an excluded chip into `twr_slow` visible. A pseudo-random sweep covers ties and all four mode codes.

// File: rtl/pair_twr_pkg.sv
package pair_twr_pkg;
    typedef enum logic [1:0] {
        MODE_PRECISE = 2'd0,
        MODE_APPROX2 = 2'd1,
        MODE_APPROX4 = 2'd2,
        MODE_SPARE   = 2'd3
    } pair_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_REPORT = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/chip_seg_compare.sv
module chip_seg_compare #(
    parameter int NUM_CHIPS = 8,
    parameter int TWR_W     = 5
) (
    input  logic [NUM_CHIPS*TWR_W-1:0] row_a,
    input  logic [NUM_CHIPS*TWR_W-1:0] row_b,
    output logic [NUM_CHIPS*TWR_W-1:0] fast_seg,
    output logic [NUM_CHIPS*TWR_W-1:0] slow_seg,
    output logic [NUM_CHIPS-1:0]       take_b
);
    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
        logic [TWR_W-1:0] va;
        logic [TWR_W-1:0] vb;
        assign va        = row_a[g*TWR_W +: TWR_W];
        assign vb        = row_b[g*TWR_W +: TWR_W];
        // ties stay with row A
        assign take_b[g] = (vb < va);
        assign fast_seg[g*TWR_W +: TWR_W] = take_b[g] ? vb : va;
        assign slow_seg[g*TWR_W +: TWR_W] = take_b[g] ? va : vb;
    end
endmodule

// File: rtl/twr_max_reduce.sv
module twr_max_reduce #(
    parameter int NUM_CHIPS = 8,
    parameter int TWR_W     = 5
) (
    input  logic [NUM_CHIPS*TWR_W-1:0] vals,
    input  logic [NUM_CHIPS-1:0]       excl,
    output logic [TWR_W-1:0]           max_o
);
    always_comb begin
        max_o = '0;
        for (int i = 0; i < NUM_CHIPS; i++) begin
            if (!excl[i] && (vals[i*TWR_W +: TWR_W] > max_o)) begin
                max_o = vals[i*TWR_W +: TWR_W];
            end
        end
    end
endmodule

// File: rtl/pair_row_twr_combiner.sv
module pair_row_twr_combiner
    import pair_twr_pkg::*;
#(
    parameter int                 NUM_CHIPS = 8,
    parameter int                 TWR_W     = 5,
    parameter logic [NUM_CHIPS-1:0] MASK_AX2 = 8'h11,
    parameter logic [NUM_CHIPS-1:0] MASK_AX4 = 8'h33
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [1:0]                 mode,
    input  logic [NUM_CHIPS*TWR_W-1:0] twr_row_a,
    input  logic [NUM_CHIPS*TWR_W-1:0] twr_row_b,
    output logic                       busy,
    output logic                       done,
    output logic [NUM_CHIPS-1:0]       swap_map,
    output logic [TWR_W-1:0]           twr_fast,
    output logic [TWR_W-1:0]           twr_slow
);
    localparam int VEC_W = NUM_CHIPS * TWR_W;

    ctrl_state_e          state_q, state_d;
    logic [VEC_W-1:0]     row_a_q, row_b_q;
    pair_mode_e           mode_q;
    logic [VEC_W-1:0]     fast_seg, slow_seg;
    logic [NUM_CHIPS-1:0] take_b;
    logic [NUM_CHIPS-1:0] slow_excl;
    logic [TWR_W-1:0]     fast_max, slow_max;
    logic                 accept;

    assign accept = (state_q == ST_IDLE) && start;

    chip_seg_compare #(.NUM_CHIPS(NUM_CHIPS), .TWR_W(TWR_W)) u_cmp (
        .row_a(row_a_q), .row_b(row_b_q),
        .fast_seg(fast_seg), .slow_seg(slow_seg), .take_b(take_b)
    );

    always_comb begin
        unique case (mode_q)
            MODE_APPROX2: slow_excl = MASK_AX2;
            MODE_APPROX4: slow_excl = MASK_AX4;
            default:      slow_excl = '0;
        endcase
    end

    twr_max_reduce #(.NUM_CHIPS(NUM_CHIPS), .TWR_W(TWR_W)) u_fast_max (
        .vals(fast_seg), .excl({NUM_CHIPS{1'b0}}), .max_o(fast_max)
    );

    twr_max_reduce #(.NUM_CHIPS(NUM_CHIPS), .TWR_W(TWR_W)) u_slow_max (
        .vals(slow_seg), .excl(slow_excl), .max_o(slow_max)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_EVAL;
            ST_EVAL:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_a_q  <= '0;
            row_b_q  <= '0;
            mode_q   <= MODE_PRECISE;
            swap_map <= '0;
            twr_fast <= '0;
            twr_slow <= '0;
        end else begin
            if (accept) begin
                row_a_q <= twr_row_a;
                row_b_q <= twr_row_b;
                mode_q  <= pair_mode_e'(mode);
            end
            if (state_q == ST_EVAL) begin
                swap_map <= take_b;
                twr_fast <= fast_max;
                twr_slow <= slow_max;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_REPORT);
endmodule

// File: rtl/pair_row_twr_combiner_chk.sv
module pair_row_twr_combiner_chk #(
    parameter int NUM_CHIPS = 8,
    parameter int TWR_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [1:0]           mode,
    input logic                 busy,
    input logic                 done,
    input logic [NUM_CHIPS-1:0] swap_map,
    input logic [TWR_W-1:0]     twr_fast,
    input logic [TWR_W-1:0]     twr_slow
);
    logic taken;
    logic cap_prec;

    assign taken = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cap_prec <= 1'b0;
        else if (taken) cap_prec <= (mode == 2'd0) || (mode == 2'd3);
    end

    assert_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> busy);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> ##1 done);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({swap_map, twr_fast, twr_slow}));

    assert_fast_le_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_prec) |-> (twr_fast <= twr_slow));
endmodule

bind pair_row_twr_combiner pair_row_twr_combiner_chk #(
    .NUM_CHIPS(NUM_CHIPS), .TWR_W(TWR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .busy(busy), .done(done), .swap_map(swap_map),
    .twr_fast(twr_fast), .twr_slow(twr_slow)
);

// File: tb/pair_row_twr_combiner_tb.sv
module pair_row_twr_combiner_tb;
    typedef struct {
        logic [7:0] swap;
        logic [4:0] fast;
        logic [4:0] slow;
        int         due;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [39:0] twr_row_a = '0;
    logic [39:0] twr_row_b = '0;
    logic        busy, done;
    logic [7:0]  swap_map;
    logic [4:0]  twr_fast, twr_slow;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   dones = 0;
    int   pushed = 0;
    exp_t sb[$];
    exp_t last;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pair_row_twr_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .twr_row_a(twr_row_a), .twr_row_b(twr_row_b),
        .busy(busy), .done(done), .swap_map(swap_map),
        .twr_fast(twr_fast), .twr_slow(twr_slow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [39:0] a, input logic [39:0] b,
                                   input logic [1:0] m);
        exp_t e;
        logic [7:0] skip;
        skip = (m == 2'd1) ? 8'h11 : (m == 2'd2) ? 8'h33 : 8'h00;
        e.swap = '0; e.fast = '0; e.slow = '0;
        for (int i = 0; i < 8; i++) begin
            logic [4:0] av, bv, lo, hi;
            av = a[i*5 +: 5];
            bv = b[i*5 +: 5];
            e.swap[i] = (bv < av);
            lo = (bv < av) ? bv : av;
            hi = (bv < av) ? av : bv;
            if (lo > e.fast) e.fast = lo;
            if (!skip[i] && hi > e.slow) e.slow = hi;
        end
        e.tag = (m == 2'd1) ? "R7" : (m == 2'd2) ? "R8" : (m == 2'd3) ? "R9" : "R6";
        return e;
    endfunction

    // caller stands just after a negedge with the design idle
    task automatic send(input logic [39:0] a, input logic [39:0] b, input logic [1:0] m);
        exp_t e;
        e = model(a, b, m);
        e.due = cyc + 2;
        sb.push_back(e);
        pushed++;
        twr_row_a = a; twr_row_b = b; mode = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [39:0] fill(input logic [4:0] v);
        logic [39:0] r;
        for (int i = 0; i < 8; i++) r[i*5 +: 5] = v;
        return r;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (sb.size() == 0) begin
                chk(1'b0, "R3 extra done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.due, "R2 latency", cyc, e.due);
                chk(swap_map == e.swap, "R4 swap_map", swap_map, e.swap);
                chk(twr_fast == e.fast, "R5 twr_fast", twr_fast, e.fast);
                chk(twr_slow == e.slow, {e.tag, " twr_slow"}, twr_slow, e.slow);
                last = e;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 reset ctrl", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({swap_map, twr_fast, twr_slow} == '0, "R1 reset data",
            {swap_map, twr_fast, twr_slow}, 0);
        chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        send(fill(5'd10), fill(5'd12), 2'd0);
        send(fill(5'd7), fill(5'd7), 2'd0);                 // ties R4
        send({8{5'd20}}, {4{5'd3, 5'd25}}, 2'd0);           // alternating R4
        send(fill(5'd0), fill(5'd31), 2'd0);
        // R7: largest slow value only on chips 0 and 4
        send({5'd2, 5'd2, 5'd2, 5'd1, 5'd2, 5'd2, 5'd2, 5'd1},
             {5'd9, 5'd9, 5'd9, 5'd30, 5'd9, 5'd9, 5'd9, 5'd31}, 2'd1);
        // R8: largest values on chips 0,1,4,5
        send({5'd2, 5'd2, 5'd1, 5'd1, 5'd2, 5'd2, 5'd1, 5'd1},
             {5'd8, 5'd8, 5'd29, 5'd28, 5'd8, 5'd8, 5'd30, 5'd31}, 2'd2);
        // R9: spare code acts as precise
        send({5'd2, 5'd2, 5'd1, 5'd1, 5'd2, 5'd2, 5'd1, 5'd1},
             {5'd8, 5'd8, 5'd29, 5'd28, 5'd8, 5'd8, 5'd30, 5'd31}, 2'd3);

        // R3: start held through both busy cycles with other data
        begin
            exp_t e;
            e = model(fill(5'd4), fill(5'd6), 2'd0);
            e.due = cyc + 2;
            sb.push_back(e);
            pushed++;
            twr_row_a = fill(5'd4); twr_row_b = fill(5'd6); mode = 2'd0; start = 1'b1;
            @(negedge clk);
            twr_row_a = fill(5'd30); twr_row_b = fill(5'd1); mode = 2'd2;
            @(negedge clk);
            @(negedge clk); start = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(dones == pushed, "R3 single result", dones, pushed);
            chk(!busy, "R3 idle again", busy, 0);
            // R10: outputs hold after done
            chk(twr_fast == 5'd4 && twr_slow == 5'd6, "R10 hold",
                {twr_fast, twr_slow}, {5'd4, 5'd6});
        end

        for (int k = 0; k < 40; k++) begin
            send({$urandom, $urandom} & 40'hFF_FFFF_FFFF & {8{5'h1F}},
                 {$urandom % 4 == 0 ? 40'd0 : {$urandom, $urandom}},
                 2'($urandom % 4));
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2 all results seen", sb.size(), 0);
        chk(dones == pushed, "R3 result count", dones, pushed);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule